// File: doc/BRIEF.md
# TCP Send Segmentation Controller

This block runs one "send data" command of a hardware TCP sender. It takes a total byte count and a payload size. It cuts the transfer into full-size packets and, when the total is not a whole multiple of the payload size, one shorter residue packet. For each packet it hands a request (payload length plus a resend flag) to the packet builder over a valid/ready handshake. A fresh packet is requested only when the transmit data buffer holds enough unsent bytes for it. The command ends once the cumulative acknowledged byte count covers the whole transfer. Busy stays high until then, and a one-cycle done pulse follows.

The residue packet is held back until acknowledgements cover every full packet sent before it. By default the residue is then requested twice, the second copy flagged as a resend, so that the receiver answers sooner. A disable bit cuts this to a single copy. An external retransmit strobe makes the block request the most recent packet again. Timeout detection, header building and checksums belong to other blocks.

The state machine has six states. IDLE waits for a start. PLAN picks the next phase from the remaining length. FILL issues full packets. GATE waits for acknowledgements and buffer data before the residue. SEND holds a request until it is accepted. DRAIN waits for the final acknowledgement. The transitions are:
- IDLE to PLAN on start.
- PLAN to FILL when at least one full packet remains.
- PLAN to GATE when only a residue remains.
- PLAN to DRAIN when nothing remains.
- FILL or GATE to SEND when a packet is issued.
- Any of PLAN, FILL, GATE or DRAIN to SEND on an honoured retransmit.
- SEND to PLAN on acceptance, unless a duplicate copy is still due.
- DRAIN to IDLE when the final byte is acknowledged.

Top module: `seg_send_ctrl`

## Requirements
- R1: A start seen while idle is accepted. From the next cycle busy is 1 and the remaining-length output equals the total length. A start while busy is ignored.
- R2: While the remaining length is at least the payload size, every fresh request carries the payload size. The remaining length drops by the request length on each accepted fresh request, and never on an accepted resend.
- R3: A fresh request is raised only if buf_count, sampled at the clock edge where the request is issued, is at least that request's length. Equality is sufficient.
- R4: When the total is exactly N times the payload size, exactly N fresh requests and no resend request occur.
- R5: A residue request (length below the payload size) is issued only once ack_bytes, compared as unsigned 32-bit, is at least the number of bytes already sent.
- R6: With dup_off = 0, the accepted residue request is followed at once by a second request of the same length with req_resend = 1. With dup_off = 1 it is issued once.
- R7: Once req_valid is 1, it stays 1 with req_len and req_resend unchanged until a cycle in which req_ready is 1.
- R8: done is a one-cycle pulse. It is raised, and busy falls, on the cycle after ack_bytes ≥ total is seen with every byte sent. It is never raised earlier.
- R9: total_len, pkt_len and dup_off are captured at the accepted start. Changing them while busy has no effect on the running command.
- R10: A retransmit strobe is honoured while busy, when no request is pending and at least one fresh packet has been accepted. It raises a request with the most recent fresh length and req_resend = 1, and leaves the remaining length unchanged. Otherwise it is ignored.
- R11: After reset, busy, req_valid and done are 0 and the remaining length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a send command |
| total_len | input | 32 | Total bytes to send (1 to 0xFFFFFFFF) |
| pkt_len | input | 16 | Payload bytes per full packet (1 to 16000, typically 1460) |
| dup_off | input | 1 | 1 disables the duplicate residue request |
| buf_count | input | 16 | Unsent bytes available in the transmit data buffer |
| ack_bytes | input | 32 | Bytes acknowledged so far in this command |
| retx_req | input | 1 | Request to resend the most recent packet |
| req_valid | output | 1 | Packet request valid |
| req_ready | input | 1 | Packet builder accepts the request |
| req_len | output | 16 | Payload length of the requested packet |
| req_resend | output | 1 | Request repeats data already sent |
| busy | output | 1 | Command in progress |
| remain_len | output | 32 | Bytes not yet handed to a fresh packet |
| done | output | 1 | One-cycle pulse when the command completes |

## Verification
A corrupted remaining-length register shows up within one cycle on remain_len. It then distorts the count and lengths of later requests, so a residue appears where a full packet belongs, or the reverse. A wrong state or a lost duplicate flag shows up at req_valid and req_resend on the next handshake, and as a premature or missing done pulse at the end of the command. The bench compares every output with a behavioural model on every cycle. A fault is therefore reported in the first cycle it becomes visible, not only in the end-of-command totals.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_FILL,
        ST_GATE,
        ST_SEND,
        ST_DRAIN
    } seg_state_t;
endpackage

// File: rtl/seg_cmp_ge.sv
module seg_cmp_ge #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         ge
);
    // unsigned magnitude compare
    assign ge = (lhs >= rhs);
endmodule

// File: rtl/seg_len_track.sv
module seg_len_track #(
    parameter int LEN_W = 32,
    parameter int PKT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             consume,
    input  logic [PKT_W-1:0] consume_val,
    output logic [LEN_W-1:0] rem,
    output logic [LEN_W-1:0] total,
    output logic [LEN_W-1:0] sent
);
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] total_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            total_q <= '0;
        end else if (load) begin
            rem_q   <= load_val;
            total_q <= load_val;
        end else if (consume) begin
            rem_q   <= rem_q - LEN_W'(consume_val);
        end
    end

    assign rem   = rem_q;
    assign total = total_q;
    assign sent  = total_q - rem_q;

    // R2: a fresh packet never takes more bytes than remain
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (LEN_W'(consume_val) <= rem_q));

    // R1: an accepted start loads the full length
    a_r1_load_total: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem_q == $past(load_val)));
endmodule

// File: rtl/seg_send_ctrl.sv
module seg_send_ctrl
    import seg_pkg::*;
#(
    parameter int LEN_W = 32,
    parameter int PKT_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic [PKT_W-1:0] pkt_len,
    input  logic             dup_off,
    input  logic [CNT_W-1:0] buf_count,
    input  logic [LEN_W-1:0] ack_bytes,
    input  logic             retx_req,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [PKT_W-1:0] req_len,
    output logic             req_resend,
    output logic             busy,
    output logic [LEN_W-1:0] remain_len,
    output logic             done
);
    localparam int NCMP = 5;
    localparam int C_ACK_SENT = 0;
    localparam int C_ACK_TOT  = 1;
    localparam int C_BUF_PKT  = 2;
    localparam int C_BUF_REM  = 3;
    localparam int C_REM_PKT  = 4;

    seg_state_t state_q, state_d;

    logic [PKT_W-1:0] pkt_q, last_q;
    logic             dup_q, dup_pend_q, sent_any_q;
    logic [LEN_W-1:0] rem, total_q, sent;
    logic [LEN_W-1:0] pkt_ext, buf_ext;
    logic [LEN_W-1:0] cmp_lhs [NCMP];
    logic [LEN_W-1:0] cmp_rhs [NCMP];
    logic [NCMP-1:0]  cmp_ge;

    logic load, accept, consume, retx_go;
    logic issue_full, issue_res, finish, rem_zero;

    assign pkt_ext  = LEN_W'(pkt_q);
    assign buf_ext  = LEN_W'(buf_count);
    assign rem_zero = (rem == '0);

    always_comb begin
        cmp_lhs[C_ACK_SENT] = ack_bytes; cmp_rhs[C_ACK_SENT] = sent;
        cmp_lhs[C_ACK_TOT]  = ack_bytes; cmp_rhs[C_ACK_TOT]  = total_q;
        cmp_lhs[C_BUF_PKT]  = buf_ext;   cmp_rhs[C_BUF_PKT]  = pkt_ext;
        cmp_lhs[C_BUF_REM]  = buf_ext;   cmp_rhs[C_BUF_REM]  = rem;
        cmp_lhs[C_REM_PKT]  = rem;       cmp_rhs[C_REM_PKT]  = pkt_ext;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        seg_cmp_ge #(.W(LEN_W)) i_cmp (
            .lhs (cmp_lhs[g]),
            .rhs (cmp_rhs[g]),
            .ge  (cmp_ge[g])
        );
    end

    seg_len_track #(.LEN_W(LEN_W), .PKT_W(PKT_W)) i_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_val    (total_len),
        .consume     (consume),
        .consume_val (req_len),
        .rem         (rem),
        .total       (total_q),
        .sent        (sent)
    );

    assign load       = (state_q == ST_IDLE) && start;
    assign accept     = (state_q == ST_SEND) && req_ready;
    assign consume    = accept && !req_resend;
    assign retx_go    = retx_req && sent_any_q &&
                        (state_q inside {ST_PLAN, ST_FILL, ST_GATE, ST_DRAIN});
    assign issue_full = (state_q == ST_FILL) && !retx_go && cmp_ge[C_BUF_PKT];
    assign issue_res  = (state_q == ST_GATE) && !retx_go &&
                        cmp_ge[C_ACK_SENT] && cmp_ge[C_BUF_REM];
    assign finish     = (state_q == ST_DRAIN) && !retx_go && cmp_ge[C_ACK_TOT];

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_PLAN;
            ST_PLAN: begin
                if (retx_go)                state_d = ST_SEND;
                else if (rem_zero)          state_d = ST_DRAIN;
                else if (cmp_ge[C_REM_PKT]) state_d = ST_FILL;
                else                        state_d = ST_GATE;
            end
            ST_FILL:  if (retx_go || issue_full) state_d = ST_SEND;
            ST_GATE:  if (retx_go || issue_res)  state_d = ST_SEND;
            ST_SEND:  if (accept && !dup_pend_q) state_d = ST_PLAN;
            ST_DRAIN: begin
                if (retx_go)     state_d = ST_SEND;
                else if (finish) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q      <= '0;
            last_q     <= '0;
            dup_q      <= 1'b0;
            dup_pend_q <= 1'b0;
            sent_any_q <= 1'b0;
            req_len    <= '0;
            req_resend <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                pkt_q      <= pkt_len;
                dup_q      <= dup_off;
                dup_pend_q <= 1'b0;
                sent_any_q <= 1'b0;
            end
            if (retx_go) begin
                req_len    <= last_q;
                req_resend <= 1'b1;
            end else if (issue_full) begin
                req_len    <= pkt_q;
                req_resend <= 1'b0;
            end else if (issue_res) begin
                req_len    <= rem[PKT_W-1:0];
                req_resend <= 1'b0;
                dup_pend_q <= !dup_q;
            end
            if (accept) begin
                if (!req_resend) begin
                    last_q     <= req_len;
                    sent_any_q <= 1'b1;
                end
                if (dup_pend_q) begin
                    req_resend <= 1'b1;
                    dup_pend_q <= 1'b0;
                end
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign req_valid  = (state_q == ST_SEND);
    assign remain_len = rem;

    // R7: request held stable until accepted
    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_len) && $stable(req_resend)));

    // R2: a fresh request never exceeds the remaining length
    a_r2_fresh_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_resend) |-> (LEN_W'(req_len) <= remain_len));

    // R2: remaining length never grows inside a command
    a_r2_rem_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (remain_len <= $past(remain_len)));

    // R3: buffer held enough bytes when a fresh request was issued
    a_r3_buffer_covers: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && !req_resend) |-> (LEN_W'($past(buf_count)) >= LEN_W'(req_len)));

    // R5: residue only after full packets are acknowledged
    a_r5_residue_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && !req_resend && (req_len < pkt_q)) |-> ($past(ack_bytes) >= sent));

    // R8: done is a single pulse outside busy
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_seg_send_ctrl.sv
module test_seg_send_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] total_len = '0;
    logic [15:0] pkt_len = 16'd1460;
    logic        dup_off = 1'b0;
    logic [15:0] buf_count = '0;
    logic [31:0] ack_bytes = '0;
    logic        retx_req = 1'b0;
    logic        req_ready = 1'b1;
    logic        req_valid, req_resend, busy, done;
    logic [15:0] req_len;
    logic [31:0] remain_len;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int n_fresh = 0;
    int n_dup = 0;

    // behavioural model state
    bit     m_busy, m_pend, m_res, m_dupl, m_plan, m_has, m_done, m_dupoff;
    longint m_rem, m_tot;
    int     m_pkt, m_len, m_last;

    always #10 clk = ~clk;

    seg_send_ctrl i_seg_send_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
        .pkt_len(pkt_len), .dup_off(dup_off), .buf_count(buf_count),
        .ack_bytes(ack_bytes), .retx_req(retx_req), .req_valid(req_valid),
        .req_ready(req_ready), .req_len(req_len), .req_resend(req_resend),
        .busy(busy), .remain_len(remain_len), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_pend = 0; m_res = 0; m_dupl = 0; m_plan = 0; m_has = 0;
        m_done = 0; m_dupoff = 0; m_rem = 0; m_tot = 0; m_pkt = 0; m_len = 0; m_last = 0;
    endtask

    task automatic model_step();
        bit nd = 0;
        longint sent;
        longint ackv = longint'(ack_bytes);
        int bufv = int'(buf_count);
        if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_tot = longint'(total_len); m_rem = m_tot;
                m_pkt = int'(pkt_len); m_dupoff = dup_off;
                m_has = 0; m_dupl = 0; m_plan = 1;
            end
        end else if (m_pend) begin
            if (req_ready) begin
                if (!m_res) begin m_rem -= m_len; m_last = m_len; m_has = 1; end
                if (m_dupl) begin m_res = 1; m_dupl = 0; end
                else begin m_pend = 0; m_plan = 1; end
            end
        end else if (retx_req && m_has) begin
            m_pend = 1; m_len = m_last; m_res = 1; m_plan = 0;
        end else if (m_plan) begin
            m_plan = 0;
        end else begin
            sent = m_tot - m_rem;
            if (m_rem >= m_pkt) begin
                if (bufv >= m_pkt) begin m_pend = 1; m_len = m_pkt; m_res = 0; end
            end else if (m_rem == 0) begin
                if (ackv >= m_tot) begin m_busy = 0; nd = 1; end
            end else if (ackv >= sent && bufv >= m_rem) begin
                m_pend = 1; m_len = int'(m_rem); m_res = 0; m_dupl = !m_dupoff;
            end
        end
        m_done = nd;
    endtask

    task automatic compare();
        chk(busy == m_busy, "R1 busy", busy, m_busy);
        chk(req_valid == m_pend, "R7 req_valid", req_valid, m_pend);
        chk(longint'(remain_len) == m_rem, "R2 remain_len", remain_len, m_rem);
        chk(done == m_done, "R8 done", done, m_done);
        if (m_pend && req_valid) begin
            chk(int'(req_len) == m_len, "R2 req_len", req_len, m_len);
            chk(req_resend == m_res, "R6 req_resend", req_resend, m_res);
        end
    endtask

    task automatic tick();
        if (req_valid && req_ready) begin
            if (req_resend) n_dup++; else n_fresh++;
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0; retx_req = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
        compare();
    endtask

    task automatic launch(input longint tot, input int pkt, input bit doff);
        total_len = 32'(tot); pkt_len = 16'(pkt); dup_off = doff;
        ack_bytes = '0; n_fresh = 0; n_dup = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // auto-acknowledge everything sent, until the command ends
    task automatic run_auto(input int limit);
        for (int i = 0; i < limit && m_busy; i++) begin
            ack_bytes = 32'(m_tot - m_rem);
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            finished = 1;
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R11 reset state
        chk(!busy && !req_valid && !done, "R11 reset outputs", {busy, req_valid, done}, 0);
        chk(remain_len == 0, "R11 reset remain", remain_len, 0);

        buf_count = 16'd2000;
        req_ready = 1'b1;

        // R4 exact multiple, and R8 done timing
        launch(40, 10, 0);
        chk(busy && remain_len == 40, "R1 start accepted", remain_len, 40);
        for (int i = 0; i < 60 && n_fresh < 4; i++) tick();
        repeat (3) tick();
        ack_bytes = 32'd39;
        repeat (5) tick();
        chk(busy == 1 && done == 0, "R8 not done before final ack", done, 0);
        ack_bytes = 32'd40;
        tick();
        chk(!busy && done, "R8 done with busy low", {busy, done}, 1);
        tick();
        chk(!done, "R8 done single pulse", done, 0);
        chk(n_fresh == 4 && n_dup == 0, "R4 request count", n_fresh * 10 + n_dup, 40);

        // R5/R6 residue held back, then duplicated
        launch(45, 10, 0);
        repeat (40) tick();
        chk(n_fresh == 4 && !req_valid, "R5 residue held", n_fresh, 4);
        chk(remain_len == 5, "R5 residue remain", remain_len, 5);
        ack_bytes = 32'd39;
        repeat (5) tick();
        chk(!req_valid, "R5 residue held at ack one short", req_valid, 0);
        ack_bytes = 32'd40;
        run_auto(60);
        chk(n_fresh == 5 && n_dup == 1, "R6 residue duplicated", n_fresh * 10 + n_dup, 51);

        // R6 duplicate disabled
        launch(25, 10, 1);
        run_auto(100);
        chk(n_fresh == 3 && n_dup == 0, "R6 single residue", n_fresh * 10 + n_dup, 30);

        // R3 buffer starvation, equality boundary, and R7 backpressure
        buf_count = 16'd9;
        launch(30, 10, 0);
        repeat (10) tick();
        chk(!req_valid && n_fresh == 0, "R3 no request with short buffer", req_valid, 0);
        buf_count = 16'd10;
        req_ready = 1'b0;
        repeat (3) tick();
        chk(req_valid && req_len == 10, "R3 request at exact buffer", req_len, 10);
        repeat (4) tick();
        chk(req_valid && req_len == 10 && remain_len == 30, "R7 held under backpressure", remain_len, 30);
        req_ready = 1'b1;
        buf_count = 16'd2000;
        run_auto(100);
        chk(n_fresh == 3 && n_dup == 0, "R4 count after backpressure", n_fresh, 3);

        // R9 inputs changed while busy, second start ignored
        launch(30, 10, 0);
        pkt_len = 16'd7; total_len = 32'd99; dup_off = 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        run_auto(100);
        chk(n_fresh == 3 && n_dup == 0, "R9 captured lengths kept", n_fresh, 3);
        chk(remain_len == 0, "R9 no reload by start while busy", remain_len, 0);

        // R10 retransmit
        launch(30, 10, 0);
        for (int i = 0; i < 20 && n_fresh < 1; i++) tick();
        buf_count = 16'd0;
        repeat (3) tick();
        retx_req = 1'b1;
        tick();
        retx_req = 1'b0;
        chk(req_valid && req_resend && req_len == 10, "R10 resend of last packet", req_len, 10);
        chk(remain_len == 20, "R10 remain unchanged", remain_len, 20);
        tick();
        buf_count = 16'd2000;
        run_auto(100);
        chk(n_fresh == 3 && n_dup == 1, "R10 total requests", n_fresh * 10 + n_dup, 31);

        // single-byte transfer with default payload: residue only
        launch(1, 1460, 0);
        run_auto(50);
        chk(n_fresh == 1 && n_dup == 1, "R6 one-byte residue", n_fresh * 10 + n_dup, 11);

        // one full default-size packet
        buf_count = 16'd1460;
        launch(1460, 1460, 0);
        run_auto(50);
        chk(n_fresh == 1 && n_dup == 0, "R4 single full packet", n_fresh * 10 + n_dup, 10);

        // maximum total length loads, then abort by reset
        buf_count = 16'd0;
        launch(64'hFFFF_FFFF, 1460, 0);
        chk(remain_len == 32'hFFFF_FFFF, "R1 max total loaded", remain_len, 64'hFFFF_FFFF);
        repeat (3) tick();
        do_reset();
        chk(!busy && remain_len == 0, "R11 reset aborts command", remain_len, 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule